// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside a processor core and decides, at each opcode boundary, whether the core fetches its next opcode or enters an interrupt. The core raises `last_cycle` during the final cycle of every opcode. In that cycle the sequencer samples any recorded NMI and IRQ transitions into pending bits, which models a two-stage pipeline. In the cycle after it, the boundary, one pending source is granted. One cycle after that, `take_int` pulses with the matching vector address.

NMI and IRQ transitions arrive as single-cycle strobes and are held until they are sampled. Each sampling consumes them, so a later entry needs a fresh edge. A lock input suppresses sampling for a window without dropping what was recorded. A masked IRQ is consumed but never taken.

Leaving reset models a delayed start: the sequencer is busy for a fixed number of steps of a fixed number of clocks, then issues the reset vector. Any NMI or IRQ strobe also produces a wake pulse that releases the core from its wait-for-interrupt state, whether or not the IRQ is masked.

Top module: `intr_entry_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle it is released, `take_int` and `wake` are 0 and `rst_busy` is 1.
- R2: After `rst_n` rises, `rst_busy` stays 1 for RST_STEPS*STEP_CLKS clock edges (132 by default). On the edge that clears it, `take_int` pulses for one cycle with `vector` = 0xFFFC. `last_cycle` is ignored while `rst_busy` is 1.
- R3: A transition recorded before or during a cycle with `last_cycle`=1 is latched at that edge. The boundary is the following cycle, and `take_int` is 1 for exactly the one cycle after the boundary. It is 0 in the boundary cycle itself.
- R4: When `int_lock` is 1 in the `last_cycle` cycle, nothing is latched and no interrupt is taken at that boundary. The recorded transition is kept and is taken at the next unlocked `last_cycle`.
- R5: A latched NMI is always taken, whatever `irq_disable` is. Its vector is 0xFFFA when `emu_mode` is 1 in the boundary cycle, and 0xFFEA when it is 0.
- R6: An IRQ transition is taken only when `irq_disable` is 0 in the `last_cycle` cycle. Its vector is 0xFFFE when `emu_mode` is 1 in the boundary cycle, and 0xFFEE when it is 0.
- R7: An IRQ transition latched while `irq_disable` is 1 is discarded. Clearing `irq_disable` afterwards and reaching a new boundary does not take it.
- R8: When NMI and IRQ are both latched at one boundary, NMI is taken first. The IRQ stays pending and is taken at the next boundary, even without a new IRQ edge.
- R9: Latching consumes a transition. A further `last_cycle` with no new strobe produces no `take_int`.
- R10: `wake` is 1 in the cycle after any `nmi_edge` or `irq_edge` strobe, including a masked IRQ, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the reset delay when released |
| nmi_edge | input | 1 | One-cycle strobe: NMI transition seen |
| irq_edge | input | 1 | One-cycle strobe: IRQ transition seen |
| irq_disable | input | 1 | Core interrupt-disable flag |
| emu_mode | input | 1 | 1 selects the emulation-mode vector set |
| int_lock | input | 1 | Suppresses sampling on the current last cycle |
| last_cycle | input | 1 | Core is in the final cycle of an opcode |
| take_int | output | 1 | One-cycle pulse: enter the interrupt at `vector` |
| vector | output | 16 | Vector address, valid while `take_int` is 1 |
| wake | output | 1 | Releases the core from wait-for-interrupt |
| rst_busy | output | 1 | Reset pre-vector delay in progress |

## Verification
The bench counts the reset delay to the exact edge. A counter off by one would move the 0xFFFC pulse by a cycle. It locks one boundary and then unlocks the next. A design that dropped the recorded edge under lock would never take the NMI, and one that ignored the lock would take it early. It latches a masked IRQ and then unmasks it. A design that kept the transition would take a stale IRQ. It also latches NMI and IRQ together, which catches a wrong priority order or an IRQ lost after the NMI is granted. Repeated boundaries without new strobes expose a strobe that is not consumed. Each source is tried in both vector modes, so a wrong mode choice shows up as a wrong address.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

   localparam logic [15:0] VEC_NMI_EMU = 16'hFFFA;
   localparam logic [15:0] VEC_NMI_NAT = 16'hFFEA;
   localparam logic [15:0] VEC_IRQ_EMU = 16'hFFFE;
   localparam logic [15:0] VEC_IRQ_NAT = 16'hFFEE;
   localparam logic [15:0] VEC_RESET   = 16'hFFFC;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_NMI  = 2'd1,
      SRC_IRQ  = 2'd2
   } src_e;

   function automatic logic [15:0] vec_of(src_e src, logic emu);
      logic [15:0] v;
      case (src)
         SRC_NMI: v = emu ? VEC_NMI_EMU : VEC_NMI_NAT;
         SRC_IRQ: v = emu ? VEC_IRQ_EMU : VEC_IRQ_NAT;
         default: v = VEC_RESET;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/intr_src_latch.sv
// Holds one transition until it is sampled, then turns it into a pending bit.
module intr_src_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic edge_in,
   input  logic latch_en,
   input  logic allow,
   input  logic clr,
   output logic pend
);
   logic trans_q;
   logic eff;

   // A strobe that arrives in the sampling cycle counts as recorded.
   assign eff = trans_q | edge_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trans_q <= 1'b0;
         pend    <= 1'b0;
      end else begin
         trans_q <= eff & ~latch_en;
         pend    <= (pend & ~clr) | (latch_en & eff & allow);
      end
   end
endmodule

// File: rtl/intr_arbiter.sv
// Fixed priority at the boundary: NMI ahead of IRQ.
module intr_arbiter
   import intr_seq_pkg::*;
(
   input  logic        bnd,
   input  logic        nmi_pend,
   input  logic        irq_pend,
   input  logic        emu,
   output logic        grant_nmi,
   output logic        grant_irq,
   output logic        grant,
   output logic [15:0] vec
);
   src_e sel;

   always_comb begin
      sel = SRC_NONE;
      if (bnd) begin
         if (nmi_pend)      sel = SRC_NMI;
         else if (irq_pend) sel = SRC_IRQ;
      end
   end

   assign grant_nmi = (sel == SRC_NMI);
   assign grant_irq = (sel == SRC_IRQ);
   assign grant     = grant_nmi | grant_irq;
   assign vec       = vec_of(sel, emu);
endmodule

// File: rtl/intr_rst_delay.sv
// Counts STEPS steps of STEP_CLKS clocks after reset release.
module intr_rst_delay #(
   parameter int STEPS     = 22,
   parameter int STEP_CLKS = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic busy,
   output logic done
);
   localparam int SUB_W  = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
   localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(STEP_CLKS - 1);
   localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(STEPS - 1);

   logic [SUB_W-1:0]  sub_q;
   logic [STEP_W-1:0] step_q;
   logic              sub_wrap;

   assign sub_wrap = (sub_q == SUB_LAST);
   assign done     = busy & sub_wrap & (step_q == STEP_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b1;
         sub_q  <= '0;
         step_q <= '0;
      end else if (busy) begin
         if (done) begin
            busy <= 1'b0;
         end
         if (sub_wrap) begin
            sub_q  <= '0;
            step_q <= step_q + 1'b1;
         end else begin
            sub_q  <= sub_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/intr_entry_seq.sv
module intr_entry_seq
   import intr_seq_pkg::*;
#(
   parameter int RST_STEPS = 22,
   parameter int STEP_CLKS = 6,
   parameter bit WAKE_REG  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        nmi_edge,
   input  logic        irq_edge,
   input  logic        irq_disable,
   input  logic        emu_mode,
   input  logic        int_lock,
   input  logic        last_cycle,
   output logic        take_int,
   output logic [15:0] vector,
   output logic        wake,
   output logic        rst_busy
);
   if (RST_STEPS < 1 || STEP_CLKS < 1) begin : g_bad_delay
      $error("intr_entry_seq: RST_STEPS and STEP_CLKS must be at least 1");
   end

   logic        latch_en;
   logic        bnd_q;
   logic        nmi_pend, irq_pend;
   logic        g_nmi, g_irq, g_any;
   logic [15:0] arb_vec;
   logic        rst_done;
   logic        take_q;
   logic [15:0] vec_q;

   assign latch_en = last_cycle & ~int_lock & ~rst_busy;

   intr_src_latch u_nmi (
      .clk(clk), .rst_n(rst_n), .edge_in(nmi_edge), .latch_en(latch_en),
      .allow(1'b1), .clr(g_nmi), .pend(nmi_pend)
   );

   intr_src_latch u_irq (
      .clk(clk), .rst_n(rst_n), .edge_in(irq_edge), .latch_en(latch_en),
      .allow(~irq_disable), .clr(g_irq), .pend(irq_pend)
   );

   intr_arbiter u_arb (
      .bnd(bnd_q), .nmi_pend(nmi_pend), .irq_pend(irq_pend), .emu(emu_mode),
      .grant_nmi(g_nmi), .grant_irq(g_irq), .grant(g_any), .vec(arb_vec)
   );

   intr_rst_delay #(.STEPS(RST_STEPS), .STEP_CLKS(STEP_CLKS)) u_rst (
      .clk(clk), .rst_n(rst_n), .busy(rst_busy), .done(rst_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bnd_q  <= 1'b0;
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         bnd_q  <= last_cycle & ~rst_busy;
         take_q <= g_any | rst_done;
         if (rst_done)   vec_q <= VEC_RESET;
         else if (g_any) vec_q <= arb_vec;
      end
   end

   assign take_int = take_q;
   assign vector   = vec_q;

   if (WAKE_REG) begin : g_wake_reg
      logic wake_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wake_q <= 1'b0;
         else        wake_q <= nmi_edge | irq_edge;
      end
      assign wake = wake_q;
   end else begin : g_wake_comb
      assign wake = nmi_edge | irq_edge;
   end
endmodule

// File: rtl/intr_entry_seq_chk.sv
module intr_entry_seq_chk #(
   parameter bit WAKE_REG = 1'b1
) (
   input logic        clk,
   input logic        rst_n,
   input logic        nmi_edge,
   input logic        irq_edge,
   input logic        emu_mode,
   input logic        last_cycle,
   input logic        take_int,
   input logic [15:0] vector,
   input logic        wake,
   input logic        rst_busy
);
   // R2: nothing is entered during the reset delay.
   a_r2_busy_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      rst_busy |-> !take_int);

   // R2: the delay ends with the reset vector.
   a_r2_reset_vector: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_busy) |-> (take_int && vector == 16'hFFFC));

   // R3: each entry follows a last cycle two edges earlier, or the end of reset.
   a_r3_take_origin: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> ($past(last_cycle, 2) || $fell(rst_busy)));

   // R5 / R6: only the five defined vectors appear.
   a_r5_legal_vector: assert property (@(posedge clk) disable iff (!rst_n)
      take_int |-> (vector == 16'hFFFA || vector == 16'hFFEA ||
                    vector == 16'hFFFE || vector == 16'hFFEE ||
                    vector == 16'hFFFC));

   // R6: the vector set follows the mode in the boundary cycle.
   a_r6_mode_select: assert property (@(posedge clk) disable iff (!rst_n)
      (take_int && vector != 16'hFFFC) |-> (vector[4] == $past(emu_mode)));

   if (WAKE_REG) begin : g_wake_chk
      // R10: every strobe wakes the core on the next cycle.
      a_r10_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
         (nmi_edge || irq_edge) |=> wake);
      // R10: no wake without a strobe.
      a_r10_no_spurious_wake: assert property (@(posedge clk) disable iff (!rst_n)
         !(nmi_edge || irq_edge) |=> !wake);
   end
endmodule

bind intr_entry_seq intr_entry_seq_chk #(.WAKE_REG(WAKE_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .nmi_edge(nmi_edge), .irq_edge(irq_edge),
   .emu_mode(emu_mode), .last_cycle(last_cycle), .take_int(take_int),
   .vector(vector), .wake(wake), .rst_busy(rst_busy)
);

// File: tb/test_intr_entry_seq.sv
module test_intr_entry_seq;
   localparam int CLK_PERIOD = 10;
   localparam int DELAY      = 22 * 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_edge = 1'b0, irq_edge = 1'b0;
   logic        irq_disable = 1'b1, emu_mode = 1'b1;
   logic        int_lock = 1'b0, last_cycle = 1'b0;
   logic        take_int, wake, rst_busy;
   logic [15:0] vector;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_entry_seq i_intr_entry_seq (
      .clk(clk), .rst_n(rst_n), .nmi_edge(nmi_edge), .irq_edge(irq_edge),
      .irq_disable(irq_disable), .emu_mode(emu_mode), .int_lock(int_lock),
      .last_cycle(last_cycle), .take_int(take_int), .vector(vector),
      .wake(wake), .rst_busy(rst_busy)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Strobe one edge and confirm the wake pulse (R10).
   task automatic strobe(logic nmi, logic irq);
      @(negedge clk);
      nmi_edge = nmi;
      irq_edge = irq;
      @(negedge clk);
      check("R10 wake after strobe", {31'd0, wake}, 32'd1);
      nmi_edge = 1'b0;
      irq_edge = 1'b0;
      @(negedge clk);
      check("R10 wake ends", {31'd0, wake}, 32'd0);
   endtask

   // One opcode boundary; checks the pulse shape and returns the result.
   task automatic boundary(string req, logic exp_take, logic [15:0] exp_vec);
      @(negedge clk);
      last_cycle = 1'b1;
      @(negedge clk);
      last_cycle = 1'b0;
      check({req, " no take in boundary cycle"}, {31'd0, take_int}, 32'd0);
      @(negedge clk);
      check({req, " take"}, {31'd0, take_int}, {31'd0, exp_take});
      if (exp_take) check({req, " vector"}, {16'd0, vector}, {16'd0, exp_vec});
      @(negedge clk);
      check({req, " pulse ends"}, {31'd0, take_int}, 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 take in reset", {31'd0, take_int}, 32'd0);
      check("R1 wake in reset", {31'd0, wake}, 32'd0);
      check("R1 busy in reset", {31'd0, rst_busy}, 32'd1);
      rst_n = 1'b1;
      repeat (DELAY - 1) @(posedge clk);
      @(negedge clk);
      check("R2 still busy before last edge", {31'd0, rst_busy}, 32'd1);
      check("R2 no take before last edge", {31'd0, take_int}, 32'd0);
      @(negedge clk);
      check("R2 reset take", {31'd0, take_int}, 32'd1);
      check("R2 reset vector", {16'd0, vector}, 32'h0000FFFC);
      check("R2 busy cleared", {31'd0, rst_busy}, 32'd0);
      @(negedge clk);
      check("R2 reset pulse ends", {31'd0, take_int}, 32'd0);
   endtask

   task automatic t_nmi_modes();
      irq_disable = 1'b1;
      emu_mode = 1'b1;
      strobe(1'b1, 1'b0);
      boundary("R5 R3 NMI emulation", 1'b1, 16'hFFFA);
      boundary("R9 NMI consumed", 1'b0, 16'h0);
      emu_mode = 1'b0;
      strobe(1'b1, 1'b0);
      boundary("R5 NMI native", 1'b1, 16'hFFEA);
   endtask

   task automatic t_irq_modes();
      irq_disable = 1'b0;
      emu_mode = 1'b1;
      strobe(1'b0, 1'b1);
      boundary("R6 IRQ emulation", 1'b1, 16'hFFFE);
      emu_mode = 1'b0;
      strobe(1'b0, 1'b1);
      boundary("R6 IRQ native", 1'b1, 16'hFFEE);
      boundary("R9 IRQ consumed", 1'b0, 16'h0);
   endtask

   task automatic t_masked_irq();
      irq_disable = 1'b1;
      strobe(1'b0, 1'b1);
      boundary("R6 masked IRQ not taken", 1'b0, 16'h0);
      irq_disable = 1'b0;
      boundary("R7 masked IRQ discarded", 1'b0, 16'h0);
   endtask

   task automatic t_lock();
      emu_mode = 1'b0;
      strobe(1'b1, 1'b0);
      int_lock = 1'b1;
      boundary("R4 locked boundary", 1'b0, 16'h0);
      int_lock = 1'b0;
      boundary("R4 NMI after unlock", 1'b1, 16'hFFEA);
   endtask

   task automatic t_priority();
      irq_disable = 1'b0;
      emu_mode = 1'b1;
      strobe(1'b1, 1'b1);
      boundary("R8 NMI first", 1'b1, 16'hFFFA);
      boundary("R8 IRQ second", 1'b1, 16'hFFFE);
      boundary("R8 nothing left", 1'b0, 16'h0);
   endtask

   initial begin
      t_reset();
      t_nmi_modes();
      t_irq_modes();
      t_masked_irq();
      t_lock();
      t_priority();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule